// File: doc/BRIEF.md
# Two-Wire Control Register Slave for a Clock Synthesizer

This block is the serial control port of a clock synthesizer. An external master reaches a small bank of eight-bit control registers over a two-wire bus with open-drain data, in the style of SMBus. The block samples both bus lines with a much faster system clock and cleans them before use. After the address byte, the first byte of every write is a command byte. This byte picks byte mode or block mode, carries a chip-select field that must be zero, and in byte mode names the register.

Byte mode moves one register. Block mode always starts at register 0 and climbs. On writes the master sends a byte count ahead of the data. On reads the slave sends the byte count first. The register contents drive the synthesizer's output enables, its spread-spectrum switch and amount, and its frequency select.

Top module: `ckgen_ctl_slave`

## Requirements
- R1: Only the 7-bit address 0x69 is acknowledged, so the first byte is D2h for a write and D3h for a read. Any other address is not acknowledged, and the slave leaves the bus alone until the next start.
- R2: After reset the registers read 0x7C, 0x00, 0xEB, 0xAF, 0x01, 0x00 for indices 0 to 5.
- R3: Command bit 7 = 1 selects byte mode. Command bits 4:0 then give the register index, and the next data byte is written to that register and acknowledged.
- R4: When command bits 6:5 are not 00, the command byte is not acknowledged. Every later byte of that transaction is also not acknowledged and changes no register.
- R5: A byte read sends D2h, the command (bit 7 = 1), a repeated start and D3h. The slave then returns the indexed register MSB first, and the master ends with a NACK and a stop.
- R6: A block write (command 0x00) takes a byte count N and then writes N bytes to registers 0, 1, 2 and upward, acknowledging each one. A data byte after the N-th is not acknowledged and is discarded.
- R7: A block read (command 0x00, repeated start, D3h) first returns the count 6 and then registers 0 to 5 in order, MSB first.
- R8: A byte write to an index above 5 is acknowledged and has no effect. A byte read from such an index returns 0x00.
- R9: A stop after any complete data byte of a block write keeps the bytes already accepted and leaves the other registers unchanged.
- R10: out_enable[k] equals bit 3+k of register 0. spread_wide equals bit 7 of register 2 (1 selects -0.5%, 0 selects -0.35%). spread_on equals bit 2 of register 2. freq_high equals bit 0 of register 2 (1 selects 200 MHz, 0 selects 100 MHz).
- R11: Each bus line passes a two-flop synchronizer and a three-sample majority vote, so a pulse on SCL that lasts one system clock is not taken as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| sda_drive_low | output | 1 | 1 pulls the data line low (open drain) |
| out_enable | output | 4 | Enables of clock outputs 1 to 4; 0 means high impedance |
| spread_on | output | 1 | Spread spectrum switched on |
| spread_wide | output | 1 | Spread amount: 1 = -0.5%, 0 = -0.35% |
| freq_high | output | 1 | Output frequency: 1 = 200 MHz, 0 = 100 MHz |

## Verification
The bench drives data bytes past the announced block count. A design that ignores the count would acknowledge the extra byte and overwrite register 3. It also sends a non-zero chip-select field followed by a data byte, and a foreign address followed by a full write. A design that only rejects the offending byte would accept the trailing data and change the output enables. Further stimulus covers a block write cut short by a stop, which catches designs that commit too much or too little, and an index above the bank, which catches aliasing onto a low register. Finally, a one-clock SCL glitch is inserted in the middle of a byte. Without the vote filter that glitch shifts an extra bit and corrupts the written value.

// File: rtl/ckgen_ctl_pkg.sv
package ckgen_ctl_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned OFFSET_W = 5;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CMD,
      PH_COUNT,
      PH_WDATA,
      PH_RDATA,
      PH_IGNORE
   } phase_t;

   function automatic logic [BYTE_W-1:0] reset_value(input int unsigned idx);
      case (idx)
         0:       return 8'h7C;
         2:       return 8'hEB;
         3:       return 8'hAF;
         4:       return 8'h01;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/ckgen_line_filter.sv
module ckgen_line_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned VOTE_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   localparam int unsigned HALF = VOTE_TAPS / 2;

   initial begin
      assert (SYNC_STAGES >= 2);
      assert (VOTE_TAPS >= 3 && (VOTE_TAPS % 2) == 1);
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [VOTE_TAPS-1:0]   vote_q;
   logic                   majority;

   assign majority = ($countones(vote_q) > int'(HALF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         vote_q <= '1;
         line_o <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         vote_q <= {vote_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
         line_o <= majority;
      end
   end

   // R11: a change of the clean line is always backed by the newest vote sample
   assert_filter_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_o) |-> ($past(vote_q[0]) == line_o));
endmodule

// File: rtl/ckgen_bus_events.sv
module ckgen_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      start_o    = scl_q & scl_i & sda_q & ~sda_i;
      stop_o     = scl_q & scl_i & ~sda_q & sda_i;
      scl_rise_o = ~scl_q & scl_i;
      scl_fall_o = scl_q & ~scl_i;
   end
endmodule

// File: rtl/ckgen_reg_bank.sv
module ckgen_reg_bank
   import ckgen_ctl_pkg::*;
#(
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned IDX_W    = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [BYTE_W-1:0]          wr_data,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [BYTE_W-1:0]          rd_data,
   output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
   initial assert (NUM_REGS >= 1 && NUM_REGS < (1 << IDX_W));

   logic wr_in_range;
   assign wr_in_range = (wr_idx < IDX_W'(NUM_REGS));

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 q <= reset_value(g);
         else if (wr_en && wr_idx == IDX_W'(g))      q <= wr_data;
      end
      assign regs_flat[g*BYTE_W +: BYTE_W] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_idx == IDX_W'(i)) rd_data = regs_flat[i*BYTE_W +: BYTE_W];
   end

   // R8: writes beyond the bank leave every register untouched
   assert_oob_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_in_range) |=> $stable(regs_flat));

   // R3: an in-range write is visible on the read port one cycle later
   assert_write_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_in_range) |=> (rd_idx != $past(wr_idx)) || (rd_data == $past(wr_data)));
endmodule

// File: rtl/ckgen_xfer_fsm.sv
module ckgen_xfer_fsm
   import ckgen_ctl_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h69,
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned IDX_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              sda_i,
   output logic              drive_low_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output logic [IDX_W-1:0]  rd_idx_o,
   input  logic [BYTE_W-1:0] rd_data_i
);
   localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_REGS);
   localparam logic [3:0]        ACK_SLOT   = 4'd8;
   localparam logic [3:0]        END_SLOT   = 4'd9;

   initial assert (IDX_W > OFFSET_W);

   phase_t            phase, next_phase;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] shreg, tx_q, remaining;
   logic [IDX_W-1:0]  ptr;
   logic              byte_mode, send_count, drive_q;
   logic              active;

   assign active      = (phase != PH_IDLE) && (phase != PH_IGNORE);
   assign drive_low_o = drive_q;
   assign rd_idx_o    = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         next_phase <= PH_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         tx_q       <= '0;
         remaining  <= '0;
         ptr        <= '0;
         byte_mode  <= 1'b0;
         send_count <= 1'b0;
         drive_q    <= 1'b0;
         wr_en_o    <= 1'b0;
         wr_idx_o   <= '0;
         wr_data_o  <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_i) begin
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            drive_q <= 1'b0;
         end else if (stop_i) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            drive_q <= 1'b0;
         end else if (active && scl_rise_i) begin
            if (bit_cnt < ACK_SLOT) begin
               if (phase != PH_RDATA) shreg <= {shreg[BYTE_W-2:0], sda_i};
               bit_cnt <= bit_cnt + 4'd1;
            end else if (bit_cnt == ACK_SLOT) begin
               if (phase == PH_RDATA && sda_i) phase <= PH_IGNORE;
               else                            bit_cnt <= END_SLOT;
            end
         end else if (active && scl_fall_i) begin
            if (bit_cnt == ACK_SLOT) begin
               drive_q <= 1'b0;
               if (phase != PH_RDATA) begin
                  next_phase <= PH_IGNORE;
                  case (phase)
                     PH_ADDR: if (shreg[7:1] == DEV_ADDR) begin
                        drive_q <= 1'b1;
                        if (shreg[0]) begin
                           next_phase <= PH_RDATA;
                           send_count <= ~byte_mode;
                        end else begin
                           next_phase <= PH_CMD;
                        end
                     end
                     PH_CMD: if (shreg[6:5] == 2'b00) begin
                        drive_q    <= 1'b1;
                        byte_mode  <= shreg[7];
                        ptr        <= shreg[7] ? IDX_W'(shreg[OFFSET_W-1:0]) : '0;
                        remaining  <= 8'd1;
                        next_phase <= shreg[7] ? PH_WDATA : PH_COUNT;
                     end
                     PH_COUNT: begin
                        drive_q    <= 1'b1;
                        remaining  <= shreg;
                        next_phase <= PH_WDATA;
                     end
                     PH_WDATA: if (remaining != '0) begin
                        drive_q    <= 1'b1;
                        wr_en_o    <= 1'b1;
                        wr_idx_o   <= ptr;
                        wr_data_o  <= shreg;
                        remaining  <= remaining - 8'd1;
                        if (ptr != '1) ptr <= ptr + IDX_W'(1);
                        next_phase <= PH_WDATA;
                     end
                     default: ;
                  endcase
               end
            end else if (bit_cnt == END_SLOT) begin
               bit_cnt <= '0;
               phase   <= next_phase;
               drive_q <= 1'b0;
               if (next_phase == PH_RDATA) begin
                  if (send_count) begin
                     tx_q       <= COUNT_BYTE;
                     drive_q    <= ~COUNT_BYTE[7];
                     send_count <= 1'b0;
                  end else begin
                     tx_q    <= rd_data_i;
                     drive_q <= ~rd_data_i[7];
                     if (ptr != '1) ptr <= ptr + IDX_W'(1);
                  end
               end
            end else if (phase == PH_RDATA && bit_cnt != '0) begin
               tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
               drive_q <= ~tx_q[BYTE_W-2];
            end
         end
      end
   end

   // R1: the slave never pulls the line while idle or shut out
   assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE || phase == PH_IGNORE) |-> !drive_q);

   // R5: the data line only moves after SCL falls or a start/stop
   assert_drive_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drive_q) |-> $past(scl_fall_i || start_i || stop_i));

   // R6: bit counter stays inside the nine-slot frame
   assert_frame_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= END_SLOT);

   // R6: register writes come only from a data byte, on an SCL fall
   assert_write_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> ($past(phase) == PH_WDATA) && $past(scl_fall_i));

   // R4: a non-zero chip-select field leaves the ACK slot released
   assert_cs_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_fall_i && !start_i && !stop_i && bit_cnt == ACK_SLOT && phase == PH_CMD
       && shreg[6:5] != 2'b00) |=> !drive_q);
endmodule

// File: rtl/ckgen_ctl_slave.sv
module ckgen_ctl_slave
   import ckgen_ctl_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h69,
   parameter int unsigned NUM_REGS    = 6,
   parameter int unsigned NUM_OUTS    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned VOTE_TAPS   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_in,
   input  logic                sda_in,
   output logic                sda_drive_low,
   output logic [NUM_OUTS-1:0] out_enable,
   output logic                spread_on,
   output logic                spread_wide,
   output logic                freq_high
);
   localparam int unsigned IDX_W    = OFFSET_W + 1;
   localparam int unsigned ENA_REG  = 0;
   localparam int unsigned ENA_LSB  = 3;
   localparam int unsigned CTL_REG  = 2;
   localparam int unsigned NUM_LINE = 2;

   initial begin
      assert (NUM_REGS > CTL_REG && NUM_REGS <= (1 << OFFSET_W));
      assert (NUM_OUTS >= 1 && ENA_LSB + NUM_OUTS <= BYTE_W);
   end

   logic [NUM_LINE-1:0] raw_lines, clean_lines;
   assign raw_lines = {sda_in, scl_in};

   for (genvar l = 0; l < NUM_LINE; l++) begin : g_line
      ckgen_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_flt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_lines[l]),
         .line_o (clean_lines[l])
      );
   end

   logic start_ev, stop_ev, rise_ev, fall_ev;
   ckgen_bus_events u_ev (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (clean_lines[0]),
      .sda_i      (clean_lines[1]),
      .start_o    (start_ev),
      .stop_o     (stop_ev),
      .scl_rise_o (rise_ev),
      .scl_fall_o (fall_ev)
   );

   logic                       wr_en;
   logic [IDX_W-1:0]           wr_idx, rd_idx;
   logic [BYTE_W-1:0]          wr_data, rd_data;
   logic [NUM_REGS*BYTE_W-1:0] regs_flat;

   ckgen_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_ev),
      .stop_i      (stop_ev),
      .scl_rise_i  (rise_ev),
      .scl_fall_i  (fall_ev),
      .sda_i       (clean_lines[1]),
      .drive_low_o (sda_drive_low),
      .wr_en_o     (wr_en),
      .wr_idx_o    (wr_idx),
      .wr_data_o   (wr_data),
      .rd_idx_o    (rd_idx),
      .rd_data_i   (rd_data)
   );

   ckgen_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .regs_flat (regs_flat)
   );

   assign out_enable  = regs_flat[ENA_REG*BYTE_W + ENA_LSB +: NUM_OUTS];
   assign spread_wide = regs_flat[CTL_REG*BYTE_W + 7];
   assign spread_on   = regs_flat[CTL_REG*BYTE_W + 2];
   assign freq_high   = regs_flat[CTL_REG*BYTE_W + 0];
endmodule

// File: tb/ckgen_ctl_slave_tb_top.sv
module ckgen_ctl_slave_tb_top;
   localparam int Q = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       sda_drv, sda_bus;
   logic [3:0] out_enable;
   logic       spread_on, spread_wide, freq_high;
   logic       glitch_en = 1'b0;
   logic       done = 1'b0;

   assign sda_bus = sda_m & ~sda_drv;

   ckgen_ctl_slave dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_in        (scl_m),
      .sda_in        (sda_bus),
      .sda_drive_low (sda_drv),
      .out_enable    (out_enable),
      .spread_on     (spread_on),
      .spread_wide   (spread_wide),
      .freq_high     (freq_high)
   );

   int          n_checks = 0, n_fail = 0;
   logic [7:0]  exp_v[$];
   string       exp_tag[$];

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver side: push the expected item
   task automatic expect_item(input logic [7:0] v, input string tag);
      exp_v.push_back(v);
      exp_tag.push_back(tag);
   endtask

   // monitor side: pop and compare against what the bus produced
   task automatic observe(input logic [7:0] got);
      logic [7:0] e;
      string      t;
      n_checks++;
      if (exp_v.size() == 0) begin
         n_fail++;
         $display("FAIL scoreboard underflow: actual %02h expected none", got);
      end else begin
         e = exp_v.pop_front();
         t = exp_tag.pop_front();
         if (got !== e) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", t, got, e);
         end
      end
   endtask

   task automatic check(input logic [7:0] got, input logic [7:0] e, input string tag);
      n_checks++;
      if (got !== e) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, got, e);
      end
   endtask

   task automatic clock_bit(input logic b, output logic s);
      tick(Q);
      sda_m = b;
      if (glitch_en) begin
         tick(Q / 2);
         scl_m = 1'b1;
         tick(1);
         scl_m = 1'b0;
         tick(Q / 2);
      end else begin
         tick(Q);
      end
      scl_m = 1'b1;
      tick(Q);
      s = sda_bus;
      tick(Q);
      scl_m = 1'b0;
   endtask

   task automatic bus_start();
      sda_m = 1'b1;
      tick(Q);
      scl_m = 1'b1;
      tick(Q);
      sda_m = 1'b0;
      tick(Q);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      tick(Q);
      sda_m = 1'b0;
      tick(Q);
      scl_m = 1'b1;
      tick(Q);
      sda_m = 1'b1;
      tick(Q);
   endtask

   // ack expectation: 0 = acknowledged, 1 = not acknowledged
   task automatic send_byte(input logic [7:0] v, input logic exp_nack, input string tag);
      logic s;
      expect_item({7'b0, exp_nack}, tag);
      for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
      clock_bit(1'b1, s);
      observe({7'b0, s});
   endtask

   task automatic recv_byte(input logic [7:0] e, input logic master_nack, input string tag);
      logic [7:0] v;
      logic       s;
      expect_item(e, tag);
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b1, s);
         v[i] = s;
      end
      clock_bit(master_nack, s);
      observe(v);
   endtask

   task automatic byte_write(input logic [7:0] cmd, input logic [7:0] d, input string tag);
      bus_start();
      send_byte(8'hD2, 1'b0, tag);
      send_byte(cmd, 1'b0, tag);
      send_byte(d, 1'b0, tag);
      bus_stop();
   endtask

   task automatic byte_read(input logic [7:0] cmd, input logic [7:0] e, input string tag);
      bus_start();
      send_byte(8'hD2, 1'b0, tag);
      send_byte(cmd, 1'b0, tag);
      bus_start();
      send_byte(8'hD3, 1'b0, tag);
      recv_byte(e, 1'b1, tag);
      bus_stop();
   endtask

   task automatic block_read(input logic [47:0] regs, input string tag);
      bus_start();
      send_byte(8'hD2, 1'b0, tag);
      send_byte(8'h00, 1'b0, tag);
      bus_start();
      send_byte(8'hD3, 1'b0, tag);
      recv_byte(8'd6, 1'b0, {tag, " count"});
      for (int i = 0; i < 6; i++)
         recv_byte(regs[i*8 +: 8], (i == 5), tag);
      bus_stop();
   endtask

   initial begin
      tick(10);
      rst_n = 1'b1;
      tick(10);

      // R2 / R10: reset state at the ports
      check({4'h0, out_enable}, 8'h0F, "R2 R10 reset out_enable");
      check({5'h0, spread_wide, spread_on, freq_high}, 8'h05, "R2 R10 reset spread/freq");
      check({7'h0, sda_drv}, 8'h00, "R1 idle bus released");

      // R7 / R2: block read of defaults
      block_read({8'h00, 8'h01, 8'hAF, 8'hEB, 8'h00, 8'h7C}, "R7 R2 default block read");

      // R3 / R10 / R5: byte write of control register, then read back
      byte_write(8'h82, 8'h04, "R3 byte write idx2");
      check({5'h0, spread_wide, spread_on, freq_high}, 8'h02, "R10 spread/freq after idx2=04");
      byte_read(8'h82, 8'h04, "R5 byte read idx2");
      byte_write(8'h80, 8'h28, "R3 byte write idx0");
      check({4'h0, out_enable}, 8'h05, "R10 out_enable after idx0=28");

      // R1: foreign address, remainder ignored
      bus_start();
      send_byte(8'hD4, 1'b1, "R1 foreign address nack");
      send_byte(8'h80, 1'b1, "R1 cmd after foreign address");
      send_byte(8'hFF, 1'b1, "R1 data after foreign address");
      bus_stop();
      check({4'h0, out_enable}, 8'h05, "R1 registers untouched");

      // R4: non-zero chip-select field
      bus_start();
      send_byte(8'hD2, 1'b0, "R4 address");
      send_byte(8'hA0, 1'b1, "R4 cs field nack");
      send_byte(8'h78, 1'b1, "R4 data after bad cs");
      bus_stop();
      check({4'h0, out_enable}, 8'h05, "R4 registers untouched");

      // R6: block write of 3 bytes plus an excess byte
      bus_start();
      send_byte(8'hD2, 1'b0, "R6 address");
      send_byte(8'h00, 1'b0, "R6 block cmd");
      send_byte(8'h03, 1'b0, "R6 count");
      send_byte(8'h40, 1'b0, "R6 data0");
      send_byte(8'h11, 1'b0, "R6 data1");
      send_byte(8'h81, 1'b0, "R6 data2");
      send_byte(8'h22, 1'b1, "R6 excess byte nack");
      bus_stop();
      check({4'h0, out_enable}, 8'h08, "R6 R10 out_enable after block");
      check({5'h0, spread_wide, spread_on, freq_high}, 8'h05, "R6 R10 spread/freq after block");
      block_read({8'h00, 8'h01, 8'hAF, 8'h81, 8'h11, 8'h40}, "R6 R7 block read back");

      // R9: stop after the first byte of a 4-byte block
      bus_start();
      send_byte(8'hD2, 1'b0, "R9 address");
      send_byte(8'h00, 1'b0, "R9 block cmd");
      send_byte(8'h04, 1'b0, "R9 count");
      send_byte(8'h08, 1'b0, "R9 data0");
      bus_stop();
      check({4'h0, out_enable}, 8'h01, "R9 first byte kept");
      byte_read(8'h81, 8'h11, "R9 idx1 unchanged");

      // R8: index above the bank
      byte_write(8'h87, 8'h55, "R8 write idx7 acked");
      byte_read(8'h87, 8'h00, "R8 read idx7");

      // R11: one-clock SCL glitches inside every low phase
      glitch_en = 1'b1;
      byte_write(8'h83, 8'h5A, "R11 glitched write idx3");
      glitch_en = 1'b0;
      block_read({8'h00, 8'h01, 8'h5A, 8'h81, 8'h11, 8'h08}, "R11 R8 final block read");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule